// File: doc/BRIEF.md
# Multi-channel prescaled interval timer

This block is a bank of independent 16-bit up-counters behind a simple synchronous register bus. Each channel has its own clock configuration with an optional power-of-two prescaler, a control register and a read-only count. It also has an interval (match) register, a pending-interrupt flag and an interrupt enable. A channel either runs freely and wraps at the top of its range, or runs in interval mode: it counts up to the programmed interval value, restarts from zero and raises its interrupt flag.

Software starts a channel by writing a control word that clears the halt bit and sets the self-acting restart bit. It acknowledges an interrupt by reading the channel's status register. Each channel drives one level interrupt line, which stays high while a flag is pending and the channel's interrupt enable is set.

The registers of successive channels are interleaved: a channel's copy of each register sits 4 bytes above the previous channel's copy.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every register reads 0, except the control register, which reads 0x01 (halted). Every interrupt line is low.
- R2: Channel n's registers are at these byte addresses plus 4*n: 0x00 clock configuration, 0x0C control, 0x18 count (read-only), 0x24 interval, 0x54 status, 0x60 interrupt enable. Read data appears on the clock edge that samples rd_en and holds until the next read. A write to the count address has no effect, and a read of an unmapped address returns 0.
- R3: A running channel in free-running mode adds one to its count on each count tick and wraps from 0xFFFF to 0.
- R4: In the clock configuration, bit 0 enables the prescaler and bits [4:1] hold an exponent E. With bit 0 set, a count tick occurs every 2^(E+1) clock cycles; with bit 0 clear, a tick occurs on every cycle.
- R5: A restart, or any write to the clock configuration, clears the prescale divider. The first increment after a restart therefore comes one full prescaled period later.
- R6: Control bit 0 halts the channel: the count and the divider hold their values. Bit 1 selects interval mode and bit 5 is a spare bit that is stored. Control reads back only bits 0, 1 and 5; all other bits read 0.
- R7: Writing 1 to control bit 4 sets the count to 0 on that write. The bit always reads back 0. It also takes effect when the same write clears the halt bit, in which case counting resumes from 0.
- R8: In interval mode with interval value V, the tick that finds the count equal to V returns the count to 0 and sets status bit 0. The flag is therefore raised every V+1 ticks.
- R9: A status read returns the pending flag and clears it. A flag raised on the same cycle as the read is kept.
- R10: A channel's interrupt line is high when its status bit 0 and its enable bit 0 are both set. With the enable at 0 the line stays low, while the status flag still sets and counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; acts as the acknowledge on the status register |
| bus_rdata | output | DATA_W | Registered read data |
| tmr_irq | output | NUM_CH | Level interrupt, one line per channel |

## Verification
The bench builds the block with its defaults: two channels, 16-bit counters and a 4-bit prescale exponent. Two channels are enough to exercise the 4-byte interleave of every register. The bench sweeps the prescaler exponents 0 to 4, with the prescaler both enabled and disabled, and samples the count just before and just after each expected tick. This makes the full-period rule after a restart or a clock-configuration write observable cycle by cycle. One full 65536-cycle free run reaches the wrap, and the interval tests place a status read on the exact cycle the flag rises.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  // register bank base offsets; channel n adds CH_STRIDE*n
  localparam int OFF_CLK    = 'h00;
  localparam int OFF_CTL    = 'h0C;
  localparam int OFF_CNT    = 'h18;
  localparam int OFF_IVL    = 'h24;
  localparam int OFF_STS    = 'h54;
  localparam int OFF_IEN    = 'h60;
  localparam int CH_STRIDE  = 4;
  // control register bit positions
  localparam int CTL_HALT   = 0;
  localparam int CTL_IVL    = 1;
  localparam int CTL_RST    = 4;
  localparam int CTL_AUX    = 5;
  localparam int CTL_W      = 6;
endpackage

// File: rtl/ttb_prescaler.sv
module ttb_prescaler #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ps_en,
  input  logic [PS_W-1:0] ps_exp,
  input  logic            run,
  input  logic            clear,
  output logic            tick
);
  localparam int DIV_W = 2 ** PS_W;
  localparam int SPN_W = DIV_W + 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [SPN_W-1:0] span;
  logic [DIV_W-1:0] term;

  always_comb begin
    span = SPN_W'(2) << ps_exp;
    term = DIV_W'(span - SPN_W'(1));
    tick = !ps_en || (div_q == term);
  end

  always_comb begin
    div_d = div_q;
    if (clear)             div_d = '0;
    else if (run && ps_en) div_d = (div_q == term) ? '0 : div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/ttb_counter.sv
module ttb_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic             ivl_mode,
  input  logic [CNT_W-1:0] ivl,
  input  logic             sts_clr,
  output logic [CNT_W-1:0] count,
  output logic             status
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sts_q, sts_d;
  logic             hit;

  always_comb begin
    hit   = step && !restart && ivl_mode && (cnt_q == ivl);
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (hit)  cnt_d = '0;
    else if (step) cnt_d = cnt_q + CNT_W'(1);
    // a flag raised on the acknowledge cycle survives
    sts_d = (sts_q && !sts_clr) || hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sts_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sts_q <= sts_d;
    end
  end

  assign count  = cnt_q;
  assign status = sts_q;
endmodule

// File: rtl/ttb_channel.sv
module ttb_channel
  import ttb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_clk,
  input  logic              wr_ctl,
  input  logic              wr_ivl,
  input  logic              wr_ien,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              sts_clr,
  output logic [PS_W:0]     clk_cfg,
  output logic [CTL_W-1:0]  ctl_cfg,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  ivl,
  output logic              ien,
  output logic              status,
  output logic              halt,
  output logic              irq
);
  logic [PS_W:0]    clk_q, clk_d;
  logic             halt_q, halt_d, ivm_q, ivm_d, aux_q, aux_d;
  logic [CNT_W-1:0] ivl_q, ivl_d;
  logic             ien_q, ien_d;
  logic             restart, tick;

  assign restart = wr_ctl && wdata[CTL_RST];

  always_comb begin
    clk_d  = wr_clk ? wdata[PS_W:0]   : clk_q;
    halt_d = wr_ctl ? wdata[CTL_HALT] : halt_q;
    ivm_d  = wr_ctl ? wdata[CTL_IVL]  : ivm_q;
    aux_d  = wr_ctl ? wdata[CTL_AUX]  : aux_q;
    ivl_d  = wr_ivl ? wdata           : ivl_q;
    ien_d  = wr_ien ? wdata[0]        : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q  <= '0;
      halt_q <= 1'b1;
      ivm_q  <= 1'b0;
      aux_q  <= 1'b0;
      ivl_q  <= '0;
      ien_q  <= 1'b0;
    end else begin
      clk_q  <= clk_d;
      halt_q <= halt_d;
      ivm_q  <= ivm_d;
      aux_q  <= aux_d;
      ivl_q  <= ivl_d;
      ien_q  <= ien_d;
    end
  end

  ttb_prescaler #(.PS_W(PS_W)) u_ps (
    .clk    (clk),
    .rst_n  (rst_n),
    .ps_en  (clk_q[0]),
    .ps_exp (clk_q[PS_W:1]),
    .run    (!halt_q),
    .clear  (restart || wr_clk),
    .tick   (tick)
  );

  ttb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (!halt_q && tick),
    .restart  (restart),
    .ivl_mode (ivm_q),
    .ivl      (ivl_q),
    .sts_clr  (sts_clr),
    .count    (count),
    .status   (status)
  );

  assign clk_cfg = clk_q;
  assign ctl_cfg = {aux_q, 3'b000, ivm_q, halt_q};
  assign ivl     = ivl_q;
  assign ien     = ien_q;
  assign halt    = halt_q;
  assign irq     = status && ien_q;
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import ttb_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] tmr_irq
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [NUM_CH-1:0]              sel_clk, sel_ctl, sel_cnt, sel_ivl, sel_sts, sel_ien;
  logic [NUM_CH-1:0][PS_W:0]      ch_clk;
  logic [NUM_CH-1:0][CTL_W-1:0]   ch_ctl;
  logic [NUM_CH-1:0][CNT_W-1:0]   ch_count, ch_ivl;
  logic [NUM_CH-1:0]              ch_ien, ch_status, ch_halt;
  logic [DATA_W-1:0]              rd_mux, rdata_q, rdata_d;
  logic                           unused_wdata;

  assign unused_wdata = ^bus_wdata;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign sel_clk[g] = (bus_addr == ADDR_W'(OFF_CLK + CH_STRIDE * g));
    assign sel_ctl[g] = (bus_addr == ADDR_W'(OFF_CTL + CH_STRIDE * g));
    assign sel_cnt[g] = (bus_addr == ADDR_W'(OFF_CNT + CH_STRIDE * g));
    assign sel_ivl[g] = (bus_addr == ADDR_W'(OFF_IVL + CH_STRIDE * g));
    assign sel_sts[g] = (bus_addr == ADDR_W'(OFF_STS + CH_STRIDE * g));
    assign sel_ien[g] = (bus_addr == ADDR_W'(OFF_IEN + CH_STRIDE * g));

    ttb_channel #(.CNT_W(CNT_W), .PS_W(PS_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .wr_clk  (bus_wr && sel_clk[g]),
      .wr_ctl  (bus_wr && sel_ctl[g]),
      .wr_ivl  (bus_wr && sel_ivl[g]),
      .wr_ien  (bus_wr && sel_ien[g]),
      .wdata   (bus_wdata[CNT_W-1:0]),
      .sts_clr (bus_rd && sel_sts[g]),
      .clk_cfg (ch_clk[g]),
      .ctl_cfg (ch_ctl[g]),
      .count   (ch_count[g]),
      .ivl     (ch_ivl[g]),
      .ien     (ch_ien[g]),
      .status  (ch_status[g]),
      .halt    (ch_halt[g]),
      .irq     (tmr_irq[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_clk[i]) rd_mux = DATA_W'(ch_clk[i]);
      if (sel_ctl[i]) rd_mux = DATA_W'(ch_ctl[i]);
      if (sel_cnt[i]) rd_mux = DATA_W'(ch_count[i]);
      if (sel_ivl[i]) rd_mux = DATA_W'(ch_ivl[i]);
      if (sel_sts[i]) rd_mux = DATA_W'(ch_status[i]);
      if (sel_ien[i]) rd_mux = DATA_W'(ch_ien[i]);
    end
    rdata_d = bus_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/ttb_checker.sv
module ttb_checker
  import ttb_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic                           bus_wr,
  input logic [DATA_W-1:0]              bus_wdata,
  input logic                           bus_rd,
  input logic [NUM_CH-1:0][CNT_W-1:0]   ch_count,
  input logic [NUM_CH-1:0]              ch_status,
  input logic [NUM_CH-1:0]              ch_halt
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    logic kick, ack;
    assign kick = bus_wr && (bus_addr == ADDR_W'(OFF_CTL + CH_STRIDE * g)) && bus_wdata[CTL_RST];
    assign ack  = bus_rd && (bus_addr == ADDR_W'(OFF_STS + CH_STRIDE * g));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_count[g] != $past(ch_count[g])) |->
        (ch_count[g] == CNT_W'($past(ch_count[g]) + CNT_W'(1))) || (ch_count[g] == '0));

    p_halt_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_halt[g] && !kick) |=> $stable(ch_count[g]));

    p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (ch_count[g] == '0));

    p_flag_on_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_status[g]) |-> (ch_count[g] == '0));

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (!ch_status[g] || (ch_count[g] == '0)));
  end
endmodule

bind tick_timer_bank ttb_checker #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_ttb_chk (
  .clk       (clk),
  .rst_n     (rst_i_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .ch_count  (ch_count),
  .ch_status (ch_status),
  .ch_halt   (ch_halt)
);

// File: tb/sim_tick_timer_bank.sv
`timescale 1ns/1ps
module sim_tick_timer_bank;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_wr, bus_rd;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic [NUM_CH-1:0] tmr_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  tick_timer_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .tmr_irq(tmr_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input int a, input int d);
    bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    bus_addr = ADDR_W'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int d, ch1;
    bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0; rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(4);

    // R1: reset values for both channels
    for (int c = 0; c < NUM_CH; c++) begin
      rd('h00 + 4*c, v); chk("R1 clk cfg", v, 0);
      rd('h0C + 4*c, v); chk("R1 control", v, 32'h01);
      rd('h18 + 4*c, v); chk("R1 count", v, 0);
      rd('h24 + 4*c, v); chk("R1 interval", v, 0);
      rd('h54 + 4*c, v); chk("R1 status", v, 0);
      rd('h60 + 4*c, v); chk("R1 enable", v, 0);
    end
    chk("R1 irq", 32'(tmr_irq), 0);

    // R2: unmapped read, read-only count, read data holds
    rd('h30, v); chk("R2 unmapped", v, 0);
    wr('h18, 'h1234); rd('h18, v); chk("R2 count write ignored", v, 0);
    wr('h24 + 4, 'h00AB); rd('h24 + 4, v); chk("R2 ch1 interval", v, 'hAB);
    idle(2); chk("R2 rdata holds", bus_rdata, 'hAB);
    rd('h24, v); chk("R2 ch0 interval untouched", v, 0);

    // R6 R7: control readback keeps bits 0,1,5; restart bit reads 0
    wr('h0C, 'h3F); rd('h0C, v); chk("R6 R7 control readback", v, 'h23);
    wr('h0C, 'h01);

    // R3 R7: restart with unhalt, count after 5 cycles
    wr('h0C, 'h10); idle(5); rd('h18, v); chk("R7 R3 count after restart", v, 5);
    // R6: halt; count advanced through the halting write edge
    wr('h0C, 'h01); idle(10); rd('h18, v); chk("R6 halted count", v, 7);
    idle(20); rd('h18, v); chk("R6 still frozen", v, 7);

    // R4 R5: prescale sweep
    for (int en = 0; en < 2; en++) begin
      for (int e = 0; e < 5; e++) begin
        int wl[4];
        d = en ? (2 << e) : 1;
        wl[0] = 0; wl[1] = d - 1; wl[2] = d; wl[3] = 3*d + 2;
        wr('h00, (e << 1) | en);
        rd('h00, v); chk("R2 R4 clk cfg readback", v, 32'((e << 1) | en));
        for (int k = 0; k < 4; k++) begin
          wr('h0C, 'h10); idle(wl[k]); rd('h18, v);
          chk("R4 R5 prescaled count", v, 32'(wl[k] / d));
        end
      end
    end
    // R5: clock-config write mid-period clears the divider (divide by 8)
    wr('h00, 'h05); wr('h0C, 'h10); idle(5); wr('h00, 'h05); idle(7);
    rd('h18, v);  chk("R5 divider cleared by cfg write", v, 0);
    rd('h18, v2); chk("R5 first tick one period later", v2, 1);

    // R3: full wrap without prescaler
    wr('h00, 0); wr('h0C, 'h10); idle(65535);
    rd('h18, v);  chk("R3 top of range", v, 'hFFFF);
    rd('h18, v2); chk("R3 wrap to zero", v2, 0);
    wr('h0C, 'h01);

    // R8 R9 R10: interval mode on channel 1, V = 6
    ch1 = 4;
    wr('h24 + ch1, 6); wr('h60 + ch1, 1); wr('h00 + ch1, 0);
    wr('h0C + ch1, 'h12); idle(6);
    chk("R8 no flag before V", 32'(tmr_irq[1]), 0);
    idle(1);
    chk("R8 R10 irq after V+1 ticks", 32'(tmr_irq[1]), 1);
    chk("R10 ch0 irq quiet", 32'(tmr_irq[0]), 0);
    rd('h54 + ch1, v); chk("R9 status read", v, 1);
    chk("R9 irq cleared by read", 32'(tmr_irq[1]), 0);
    rd('h54 + ch1, v); chk("R9 status cleared", v, 0);

    // R9: read on the cycle the flag rises keeps the flag
    wr('h0C + ch1, 'h12); idle(6);
    rd('h54 + ch1, v); chk("R9 collision read returns old", v, 0);
    chk("R9 collision flag kept", 32'(tmr_irq[1]), 1);
    rd('h54 + ch1, v); chk("R9 kept flag readable", v, 1);

    // R10: enable cleared, flag still sets, line stays low
    wr('h60 + ch1, 0); wr('h0C + ch1, 'h12);
    v2 = 0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (tmr_irq[1]) v2 = 1;
    end
    chk("R10 irq suppressed", v2, 0);
    rd('h54 + ch1, v); chk("R10 status still set", v, 1);
    rd('h0C + ch1, v); chk("R6 ch1 control", v, 'h02);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule